// File: doc/BRIEF.md
# USB Root Hub Status Register

This block is the hub-wide control/status word of a USB host controller's root hub. It is a 32-bit register on a plain register bus with a write strobe, write data and combinational read data. The low half reports hub status and the high half reports hub status change flags. Several bit positions act differently on read and on write. Some are write-1-to-set, some are write-1-to-clear, and some are command bits that always read back as zero.

Command writes drive the power enables of a parameterised number of downstream ports. In global power mode a command reaches every port. In per-port mode it reaches only the ports whose mask bit is clear. A global overcurrent input is synchronised, stored and watched for changes. A connect-status change on any port, while remote wake-up is enabled and the hub is suspended, resumes the hub and raises a resume-detected flag.

No data streams through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal, and a write completes in the cycle its strobe is high.

Top module: `rh_hub_status`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `port_power` is 0, `suspended` is 0, and `resume_pulse` and `resume_sticky` are 0.
- R2: Only bits 17, 15 and 1 of `rd_data` can ever read as 1. Bits 31, 30:18, 16, 14:2 and 0 read 0, and writing 1 to the reserved ranges changes nothing.
- R3: Bit 15 reads the remote wake-up enable flag. Writing 1 to bit 15 sets it and writing 1 to bit 31 clears it. If both are 1 in one write, the clear wins. Zeros in these bits have no effect.
- R4: With `power_mode`=0 (global), writing 1 to bit 16 sets every `port_power` bit. Writing 1 to bit 0 clears every bit. Without a write, `port_power` holds.
- R5: With `power_mode`=1 (per-port), bit-16 and bit-0 commands change only the ports whose `port_mask` bit is 0. Masked ports hold their value.
- R6: When one write has both bit 16 and bit 0 set, the power-off command wins on every port it reaches.
- R7: `oc_in` passes through a two-flop synchroniser into bit 1. A level applied before clock edge k reads at bit 1 after edge k+2.
- R8: Bit 17 is set in the cycle bit 1 changes value. Writing 1 to bit 17 clears it. A change in the same cycle as the clear leaves bit 17 set.
- R9: While `oc_per_port_cfg`=1, bit 1 reads 0 and no overcurrent change is flagged from `oc_in`.
- R10: A suspended hub with the wake-up enable flag set that sees any `conn_change` bit is resumed. After that edge, `suspended` is 0, `resume_pulse` is 1 for exactly one cycle and `resume_sticky` is 1. With the flag clear, `conn_change` has no effect.
- R11: `suspend_req` puts the hub into the suspended state at the next edge. `resume_sticky` stays set until a `resume_clr` pulse clears it. A resume event in the same cycle as the clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| power_mode | input | 1 | 0 = global power switching, 1 = per-port |
| port_mask | input | NPORT | Per-port mask; 1 excludes the port from hub power commands in per-port mode |
| oc_per_port_cfg | input | 1 | 1 = per-port overcurrent protection; the global indicator is forced to 0 |
| oc_in | input | 1 | Asynchronous global overcurrent level |
| conn_change | input | NPORT | Per-port connect-status-change indications |
| suspend_req | input | 1 | Request to enter the suspended state |
| resume_clr | input | 1 | Clears the sticky resume-detected flag |
| port_power | output | NPORT | Port power enables |
| suspended | output | 1 | Hub is in the suspended state |
| resume_pulse | output | 1 | One-cycle resume-detected interrupt |
| resume_sticky | output | 1 | Sticky resume-detected flag |

## Verification
A wrong wake-up enable flag shows on `rd_data[15]` one cycle after the write. If the flag is wrong while the hub is suspended, it also shows as a missing or extra `resume_pulse` on the edge after a `conn_change`. A corrupted port power bit shows on `port_power` right after the write that should have set it, and a masked port that changes exposes wrong fan-out in per-port mode. Faults in the synchroniser or the change detector show as bit 1 or bit 17 appearing a cycle early, a cycle late or not at all. That is why the bench samples the third edge after an `oc_in` step.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int DW = 32;
  localparam int B_DRWE_CLR = 31;
  localparam int B_OC_CHG   = 17;
  localparam int B_PWR_ON   = 16;
  localparam int B_DRWE     = 15;
  localparam int B_OC       = 1;
  localparam int B_PWR_OFF  = 0;
  localparam logic [DW-1:0] LIVE_RD_MASK =
    (32'd1 << B_OC_CHG) | (32'd1 << B_DRWE) | (32'd1 << B_OC);
  typedef enum logic {HUB_RUN = 1'b0, HUB_SUSP = 1'b1} hub_state_e;
endpackage

// File: rtl/rh_sync2.sv
module rh_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rh_port_power.sv
module rh_port_power #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             per_port,
  input  logic [NPORT-1:0] mask,
  output logic [NPORT-1:0] pwr
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic reach;
    assign reach = !per_port || !mask[i];
    always_ff @(posedge clk) begin
      if (rst)                 pwr[i] <= 1'b0;
      else if (cmd_off && reach) pwr[i] <= 1'b0;
      else if (cmd_on && reach)  pwr[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/rh_wake_fsm.sv
module rh_wake_fsm #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_en,
  input  logic [NPORT-1:0] conn_change,
  input  logic             suspend_req,
  input  logic             resume_clr,
  output logic             suspended,
  output logic             resume_pulse,
  output logic             resume_sticky
);
  import rh_pkg::*;
  hub_state_e st, st_n;
  logic wake_ev;

  assign wake_ev   = (st == HUB_SUSP) && wake_en && (|conn_change);
  assign suspended = (st == HUB_SUSP);

  always_comb begin
    st_n = st;
    if (wake_ev)          st_n = HUB_RUN;
    else if (suspend_req) st_n = HUB_SUSP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= HUB_RUN;
      resume_pulse  <= 1'b0;
      resume_sticky <= 1'b0;
    end else begin
      st            <= st_n;
      resume_pulse  <= wake_ev;
      resume_sticky <= wake_ev || (resume_sticky && !resume_clr);
    end
  end
endmodule

// File: rtl/rh_hub_status.sv
module rh_hub_status #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             power_mode,
  input  logic [NPORT-1:0] port_mask,
  input  logic             oc_per_port_cfg,
  input  logic             oc_in,
  input  logic [NPORT-1:0] conn_change,
  input  logic             suspend_req,
  input  logic             resume_clr,
  output logic [NPORT-1:0] port_power,
  output logic             suspended,
  output logic             resume_pulse,
  output logic             resume_sticky
);
  import rh_pkg::*;

  logic wake_en, oc_sync, oc_eff, oc_q, oc_chg;
  logic w_on, w_off, w_set_en, w_clr_en, w_clr_chg;
  logic unused_wr_bits;

  assign w_on      = wr_en && wr_data[B_PWR_ON];
  assign w_off     = wr_en && wr_data[B_PWR_OFF];
  assign w_set_en  = wr_en && wr_data[B_DRWE];
  assign w_clr_en  = wr_en && wr_data[B_DRWE_CLR];
  assign w_clr_chg = wr_en && wr_data[B_OC_CHG];
  assign unused_wr_bits = ^(wr_data & ~LIVE_RD_MASK);

  rh_sync2 #(.W(1)) u_oc_sync (
    .clk(clk), .rst(rst), .d(oc_in), .q(oc_sync)
  );

  assign oc_eff = oc_sync && !oc_per_port_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q    <= 1'b0;
      oc_chg  <= 1'b0;
      wake_en <= 1'b0;
    end else begin
      oc_q   <= oc_eff;
      oc_chg <= (oc_eff != oc_q) || (oc_chg && !w_clr_chg);
      if (w_clr_en)      wake_en <= 1'b0;
      else if (w_set_en) wake_en <= 1'b1;
    end
  end

  rh_port_power #(.NPORT(NPORT)) u_pwr (
    .clk(clk), .rst(rst), .cmd_on(w_on), .cmd_off(w_off),
    .per_port(power_mode), .mask(port_mask), .pwr(port_power)
  );

  rh_wake_fsm #(.NPORT(NPORT)) u_wake (
    .clk(clk), .rst(rst), .wake_en(wake_en), .conn_change(conn_change),
    .suspend_req(suspend_req), .resume_clr(resume_clr),
    .suspended(suspended), .resume_pulse(resume_pulse),
    .resume_sticky(resume_sticky)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[B_OC_CHG] = oc_chg;
    rd_data[B_DRWE]   = wake_en;
    rd_data[B_OC]     = oc_q;
  end
endmodule

// File: rtl/rh_status_chk.sv
module rh_status_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             power_mode,
  input logic [NPORT-1:0] port_mask,
  input logic [NPORT-1:0] port_power,
  input logic             suspended,
  input logic             resume_pulse,
  input logic             resume_sticky,
  input logic             resume_clr
);
  import rh_pkg::*;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_RD_MASK) == '0);

  assert_drwe_clear_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[31] |=> !rd_data[15]);

  assert_global_on_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && !power_mode && wr_data[16] && !wr_data[0] |=> &port_power);

  assert_power_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(port_power));

  assert_masked_hold_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && power_mode |=> (($past(port_mask)) & (port_power ^ $past(port_power))) == '0);

  assert_off_wins_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en && !power_mode && wr_data[0] |=> port_power == '0);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse);

  assert_pulse_state_R10: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> resume_sticky && !suspended);

  assert_sticky_clear_R11: assert property (@(posedge clk) disable iff (rst)
    resume_clr |=> resume_sticky == resume_pulse);
endmodule

bind rh_hub_status rh_status_chk #(.NPORT(NPORT)) u_rh_status_chk (.*);

// File: tb/test_rh_hub_status.sv
module test_rh_hub_status;
  localparam int NPORT = 4;
  localparam time CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rst, wr_en, power_mode, oc_per_port_cfg, oc_in, suspend_req, resume_clr;
  logic [31:0] wr_data, rd_data;
  logic [NPORT-1:0] port_mask, conn_change, port_power;
  logic suspended, resume_pulse, resume_sticky;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rh_hub_status #(.NPORT(NPORT)) i_rh_hub_status (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .power_mode(power_mode), .port_mask(port_mask), .oc_per_port_cfg(oc_per_port_cfg),
    .oc_in(oc_in), .conn_change(conn_change), .suspend_req(suspend_req),
    .resume_clr(resume_clr), .port_power(port_power), .suspended(suspended),
    .resume_pulse(resume_pulse), .resume_sticky(resume_sticky)
  );

  // Vector table: write data, mode, mask, expected port_power, expected rd_data
  localparam logic [31:0] V_WD [NVEC] = '{
    32'h0001_0000, 32'h0000_0001, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001,
    32'h0001_0001, 32'h0000_8000, 32'h0000_0000, 32'h8000_0000, 32'h8000_8000,
    32'h7FFE_7FFE, 32'h0000_8000, 32'h0001_0000};
  localparam logic V_MODE [NVEC] = '{0,0,1,1,1,0,0,0,0,0,0,1,1};
  localparam logic [NPORT-1:0] V_MASK [NVEC] = '{
    4'h0, 4'h0, 4'h5, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF};
  localparam logic [NPORT-1:0] V_PP [NVEC] = '{
    4'hF, 4'h0, 4'hA, 4'hF, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
  localparam logic [31:0] V_RD [NVEC] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8000, 32'h8000, 32'h0, 32'h0,
    32'h0, 32'h8000, 32'h8000};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_data = '0; power_mode = 0; port_mask = '0;
    oc_per_port_cfg = 0; oc_in = 0; conn_change = '0; suspend_req = 0; resume_clr = 0;
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    chk(port_power == 0, "R1 port_power", 32'(port_power), 0);
    chk({suspended, resume_pulse, resume_sticky} == 3'b000, "R1 wake outputs",
        32'({suspended, resume_pulse, resume_sticky}), 0);

    // R2..R6 vector table
    for (int i = 0; i < NVEC; i++) begin
      power_mode = V_MODE[i]; port_mask = V_MASK[i];
      do_write(V_WD[i]);
      chk(port_power == V_PP[i], $sformatf("R4/R5/R6 vec %0d port_power", i),
          32'(port_power), 32'(V_PP[i]));
      chk(rd_data == V_RD[i], $sformatf("R2/R3 vec %0d rd_data", i), rd_data, V_RD[i]);
    end
    power_mode = 0; port_mask = '0;
    do_write(32'h8000_0000);

    // R7 synchroniser latency
    oc_in = 1;
    tick(2);
    chk(rd_data[1] == 1'b0, "R7 bit1 before third edge", 32'(rd_data[1]), 0);
    tick(1);
    chk(rd_data == 32'h0002_0002, "R7 R8 bit1 and change", rd_data, 32'h0002_0002);
    do_write(32'h0002_0000);
    chk(rd_data == 32'h0000_0002, "R8 w1c of bit17", rd_data, 32'h0000_0002);
    do_write(32'h0000_0000);
    chk(rd_data == 32'h0000_0002, "R8 zero write no effect", rd_data, 32'h0000_0002);
    // R8 set wins over clear in same cycle
    oc_in = 0;
    tick(2);
    wr_en = 1; wr_data = 32'h0002_0000;
    tick(1);
    wr_en = 0; wr_data = '0;
    chk(rd_data == 32'h0002_0000, "R8 set beats clear", rd_data, 32'h0002_0000);
    do_write(32'h0002_0000);
    chk(rd_data == 0, "R8 cleared", rd_data, 0);

    // R9 per-port overcurrent configuration
    oc_per_port_cfg = 1; oc_in = 1;
    tick(4);
    chk(rd_data == 0, "R9 forced indicator", rd_data, 0);
    oc_in = 0; tick(3); oc_per_port_cfg = 0; tick(1);

    // R11 suspend entry
    suspend_req = 1; tick(1); suspend_req = 0;
    chk(suspended == 1'b1, "R11 suspend entry", 32'(suspended), 1);
    // R10 wake-up disabled: ignored
    conn_change = 4'h2; tick(1); conn_change = '0;
    chk({suspended, resume_pulse, resume_sticky} == 3'b100, "R10 disabled wake ignored",
        32'({suspended, resume_pulse, resume_sticky}), 32'h4);
    do_write(32'h0000_8000);
    conn_change = 4'h8; tick(1); conn_change = '0;
    chk({suspended, resume_pulse, resume_sticky} == 3'b011, "R10 resume event",
        32'({suspended, resume_pulse, resume_sticky}), 32'h3);
    tick(1);
    chk({resume_pulse, resume_sticky} == 2'b01, "R10 pulse one cycle",
        32'({resume_pulse, resume_sticky}), 32'h1);
    resume_clr = 1; tick(1); resume_clr = 0;
    chk(resume_sticky == 1'b0, "R11 sticky cleared", 32'(resume_sticky), 0);
    // R11 set beats clear
    suspend_req = 1; tick(1); suspend_req = 0;
    conn_change = 4'h1; resume_clr = 1; tick(1); conn_change = '0; resume_clr = 0;
    chk({suspended, resume_sticky} == 2'b01, "R11 resume beats clear",
        32'({suspended, resume_sticky}), 32'h1);

    // R1 reset returns everything
    do_write(32'h0001_0000);
    rst = 1; tick(1); rst = 0;
    chk(rd_data == 0 && port_power == 0 && !resume_sticky && !suspended, "R1 re-reset",
        rd_data | 32'(port_power), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule